// File: doc/BRIEF.md
# Keyed GPIO Port with Address-Masked Data Access

This block is an eight-pin general-purpose I/O port attached to a simple 32-bit register bus with a 4 KB byte-offset window. A per-pin direction register splits the pins into outputs, driven from the data register, and inputs, which are sampled into the data register on every clock. The whole 1 KB region below offset 0x400 aliases the data register. Byte-offset bits [9:2] act as a per-bit mask, so software can read or change any subset of pins in one access without a read-modify-write sequence.

Alternate-function selection is protected. A write to the alternate-function register only reaches the bits enabled in a commit mask. That mask can only be rewritten after a 32-bit unlock key has been written to the lock register. The port also holds an interrupt unit (per-pin level or edge detection, a mask, a write-one-to-clear status and a single OR-ed interrupt output), eight plain pad-control storage registers, and a read-only identification area.

Bus reads are combinational in the cycle the access is presented. Writes take effect at the clock edge that ends the access cycle.

Top module: `keyed_gpio`

## Requirements
- R1: After reset, the port is locked (lock register at 0x520 reads 1), the commit mask at 0x524 reads 0xFF, and every other register reads 0. `pinOut`, `altFuncSel` and `irqOut` are 0.
- R2: A read at any word-aligned offset below 0x400 returns the data register ANDed with byte-offset bits [9:2].
- R3: A write below 0x400 changes only the data bits that are set both in byte-offset bits [9:2] and in the direction register (0x400, 1 = output). All other data bits keep their value.
- R4: On each clock, every data bit whose direction bit is 0 takes the value of its `pinIn` bit, which is visible in the next cycle. `pinIn` bits of output pins have no effect on the data register.
- R5: When an output data bit changes, the matching `pinOut` bit takes the new value one cycle later. `pinOut` bits of input pins hold their value.
- R6: Writing 0x0ACCE551 to 0x520 unlocks the port (reads 0). Writing any other value locks it (reads 1).
- R7: A write to the commit mask (0x524) takes effect only while the port is unlocked. A write to alternate-function select (0x420) changes only the bits set in the commit mask. The register value appears on `altFuncSel`.
- R8: Direction (0x400), interrupt sense (0x404), both-edges (0x408), event (0x40C), interrupt mask (0x410) and the eight pad-control registers at 0x500 to 0x51C are plain 8-bit read/write registers.
- R9: Word reads at 0xFD0, 0xFD4, … 0xFFC return the bytes 00,00,00,00,61,00,18,01,0D,F0,05,B1 in that order.
- R10: A read of an unmapped or misaligned offset, or of the write-only clear register 0x41C, returns 0. Writes to unmapped offsets change no register.
- R11: For an input pin with sense bit 0, its raw status bit (0x414) is set one cycle after its data bit changes. With both-edges bit 1, either edge sets it. With both-edges bit 0, event bit 1 selects a rising edge and event bit 0 a falling edge. Output pins never set raw status.
- R12: For an input pin with sense bit 1, its raw status bit follows, one cycle late, whether the data bit equals the event bit.
- R13: Writing to 0x41C clears every edge-mode raw status bit written as 1. Level-mode bits keep following their level.
- R14: Masked status at 0x418 is the raw status ANDed with the interrupt mask, and `irqOut` is the OR of the masked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, zero when idle |
| pinIn | input | 8 | Pin input levels, synchronous to clk |
| pinOut | output | 8 | Driven pin levels |
| altFuncSel | output | 8 | Alternate-function select per pin |
| irqOut | output | 1 | OR of masked interrupt status |

## Verification
Read data is combinational, so each read is sampled about one nanosecond after the access is driven in the low half of the clock. A register write is observed by a read started at the next falling edge. An output pin changes one edge after its data bit, so `pinOut` is only checked once a further falling edge has passed after the write. A `pinIn` change reaches the data register one edge later and raw status and `irqOut` one edge after that. Each scenario therefore waits exactly one extra falling edge between the data check and the interrupt check.

// File: rtl/keyed_gpio_pkg.sv
package keyed_gpio_pkg;

  localparam int GPIO_PINS = 8;
  localparam int BUS_AW    = 12;
  localparam int BUS_DW    = 32;
  localparam int PAD_COUNT = 8;
  localparam int PAD_IW    = $clog2(PAD_COUNT);
  localparam int ID_IW     = 4;

  localparam logic [BUS_AW-1:0] DATA_SPAN  = 12'h400;
  localparam logic [BUS_AW-1:0] OFS_DIR    = 12'h400;
  localparam logic [BUS_AW-1:0] OFS_SENSE  = 12'h404;
  localparam logic [BUS_AW-1:0] OFS_BOTH   = 12'h408;
  localparam logic [BUS_AW-1:0] OFS_EVENT  = 12'h40C;
  localparam logic [BUS_AW-1:0] OFS_MASK   = 12'h410;
  localparam logic [BUS_AW-1:0] OFS_RAW    = 12'h414;
  localparam logic [BUS_AW-1:0] OFS_MIS    = 12'h418;
  localparam logic [BUS_AW-1:0] OFS_CLEAR  = 12'h41C;
  localparam logic [BUS_AW-1:0] OFS_AFSEL  = 12'h420;
  localparam logic [BUS_AW-1:0] PAD_BASE   = 12'h500;
  localparam logic [BUS_AW-1:0] OFS_LOCK   = 12'h520;
  localparam logic [BUS_AW-1:0] OFS_COMMIT = 12'h524;
  localparam logic [BUS_AW-1:0] ID_BASE    = 12'hFD0;

  localparam logic [BUS_DW-1:0] UNLOCK_KEY = 32'h0ACCE551;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_SENSE, RD_BOTH, RD_EVENT, RD_MASK,
    RD_RAW, RD_MIS, RD_AFSEL, RD_PAD, RD_LOCK, RD_COMMIT, RD_ID
  } rdSel_e;

  typedef struct packed {
    logic                 wrData;
    logic                 wrDir;
    logic                 wrSense;
    logic                 wrBoth;
    logic                 wrEvent;
    logic                 wrMask;
    logic                 wrClear;
    logic                 wrAfsel;
    logic                 wrPad;
    logic [PAD_IW-1:0]    padIdx;
    logic [ID_IW-1:0]     idIdx;
    logic [GPIO_PINS-1:0] addrMask;
    rdSel_e               rdSel;
  } gpioStrobes_t;

  function automatic logic [7:0] idByte(input logic [ID_IW-1:0] idx);
    case (idx)
      4'd4:    idByte = 8'h61;
      4'd6:    idByte = 8'h18;
      4'd7:    idByte = 8'h01;
      4'd8:    idByte = 8'h0D;
      4'd9:    idByte = 8'hF0;
      4'd10:   idByte = 8'h05;
      4'd11:   idByte = 8'hB1;
      default: idByte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/keyed_gpio_ctrl.sv
module keyed_gpio_ctrl
  import keyed_gpio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [BUS_AW-1:0]    busAddr,
  input  logic [BUS_DW-1:0]    busWdata,
  output gpioStrobes_t         strobes,
  output logic                 locked,
  output logic [GPIO_PINS-1:0] commitMask
);

  logic   aligned, isRead, isWrite, wrLock, wrCommit;
  rdSel_e sel;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign isRead  = busSel & ~busWrite & aligned;
  assign isWrite = busSel & busWrite & aligned;

  always_comb begin
    strobes          = '0;
    strobes.addrMask = busAddr[GPIO_PINS+1:2];
    strobes.padIdx   = busAddr[PAD_IW+1:2];
    strobes.idIdx    = ID_IW'((busAddr - ID_BASE) >> 2);
    sel      = RD_NONE;
    wrLock   = 1'b0;
    wrCommit = 1'b0;
    if (busAddr < DATA_SPAN) begin
      sel            = RD_DATA;
      strobes.wrData = isWrite;
    end else if (busAddr >= ID_BASE) begin
      sel = RD_ID;
    end else if (busAddr >= PAD_BASE && busAddr < PAD_BASE + BUS_AW'(PAD_COUNT * 4)) begin
      sel           = RD_PAD;
      strobes.wrPad = isWrite;
    end else begin
      case (busAddr)
        OFS_DIR:    begin sel = RD_DIR;    strobes.wrDir   = isWrite; end
        OFS_SENSE:  begin sel = RD_SENSE;  strobes.wrSense = isWrite; end
        OFS_BOTH:   begin sel = RD_BOTH;   strobes.wrBoth  = isWrite; end
        OFS_EVENT:  begin sel = RD_EVENT;  strobes.wrEvent = isWrite; end
        OFS_MASK:   begin sel = RD_MASK;   strobes.wrMask  = isWrite; end
        OFS_RAW:    sel = RD_RAW;
        OFS_MIS:    sel = RD_MIS;
        OFS_CLEAR:  strobes.wrClear = isWrite;
        OFS_AFSEL:  begin sel = RD_AFSEL;  strobes.wrAfsel = isWrite; end
        OFS_LOCK:   begin sel = RD_LOCK;   wrLock   = isWrite; end
        OFS_COMMIT: begin sel = RD_COMMIT; wrCommit = isWrite; end
        default:    sel = RD_NONE;
      endcase
    end
    strobes.rdSel = isRead ? sel : RD_NONE;
  end

  // Key-guarded commit mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked     <= 1'b1;
      commitMask <= '1;
    end else begin
      if (wrLock)
        locked <= (busWdata != UNLOCK_KEY);
      if (wrCommit && !locked)
        commitMask <= busWdata[GPIO_PINS-1:0];
    end
  end

endmodule

// File: rtl/keyed_gpio_irq.sv
module keyed_gpio_irq
  import keyed_gpio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [GPIO_PINS-1:0] curBits,
  input  logic [GPIO_PINS-1:0] prevBits,
  input  logic [GPIO_PINS-1:0] dirBits,
  input  logic [GPIO_PINS-1:0] senseBits,
  input  logic [GPIO_PINS-1:0] bothBits,
  input  logic [GPIO_PINS-1:0] evtBits,
  input  logic                 clrStb,
  input  logic [GPIO_PINS-1:0] clrBits,
  output logic [GPIO_PINS-1:0] rawBits
);

  logic [GPIO_PINS-1:0] edgeHit, levelSel, clrApplied, rawNext;

  always_comb begin
    edgeHit = ~senseBits & ~dirBits &
              ((bothBits & (curBits ^ prevBits)) |
               (~bothBits &  evtBits &  curBits & ~prevBits) |
               (~bothBits & ~evtBits & ~curBits &  prevBits));
    levelSel   = senseBits & ~dirBits;
    clrApplied = clrStb ? clrBits : '0;
    rawNext    = (((rawBits & ~clrApplied) | edgeHit) & ~levelSel) |
                 (levelSel & ~(curBits ^ evtBits));
  end

  always_ff @(posedge clk) begin
    if (!rstN) rawBits <= '0;
    else       rawBits <= rawNext;
  end

endmodule

// File: rtl/keyed_gpio_datapath.sv
module keyed_gpio_datapath
  import keyed_gpio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  gpioStrobes_t         strobes,
  input  logic [GPIO_PINS-1:0] wrByte,
  input  logic [GPIO_PINS-1:0] pinIn,
  input  logic                 locked,
  input  logic [GPIO_PINS-1:0] commitMask,
  output logic [BUS_DW-1:0]    busRdata,
  output logic [GPIO_PINS-1:0] pinOut,
  output logic [GPIO_PINS-1:0] altFuncSel,
  output logic [GPIO_PINS-1:0] dataBits,
  output logic [GPIO_PINS-1:0] dirBits,
  output logic [GPIO_PINS-1:0] rawBits,
  output logic                 irqOut
);

  logic [GPIO_PINS-1:0] prevBits, senseQ, bothQ, evtQ, maskQ;
  logic [GPIO_PINS-1:0] wrSel, dataNext, pinUpd, rd8;
  logic [GPIO_PINS-1:0] padQ [PAD_COUNT];

  // Data register: bus writes reach outputs, pins reach inputs
  always_comb begin
    wrSel    = strobes.wrData ? (strobes.addrMask & dirBits) : '0;
    dataNext = (dataBits & ~wrSel) | (wrByte & wrSel);
    dataNext = (dataNext & dirBits) | (pinIn & ~dirBits);
    pinUpd   = (dataBits ^ prevBits) & dirBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataBits   <= '0;
      prevBits   <= '0;
      pinOut     <= '0;
      dirBits    <= '0;
      senseQ     <= '0;
      bothQ      <= '0;
      evtQ       <= '0;
      maskQ      <= '0;
      altFuncSel <= '0;
    end else begin
      dataBits <= dataNext;
      prevBits <= dataBits;
      pinOut   <= (pinOut & ~pinUpd) | (dataBits & pinUpd);
      if (strobes.wrDir)   dirBits <= wrByte;
      if (strobes.wrSense) senseQ  <= wrByte;
      if (strobes.wrBoth)  bothQ   <= wrByte;
      if (strobes.wrEvent) evtQ    <= wrByte;
      if (strobes.wrMask)  maskQ   <= wrByte;
      if (strobes.wrAfsel)
        altFuncSel <= (altFuncSel & ~commitMask) | (wrByte & commitMask);
    end
  end

  // Pad-control storage
  for (genvar g = 0; g < PAD_COUNT; g++) begin : gPad
    always_ff @(posedge clk) begin
      if (!rstN)
        padQ[g] <= '0;
      else if (strobes.wrPad && strobes.padIdx == PAD_IW'(g))
        padQ[g] <= wrByte;
    end
  end

  keyed_gpio_irq u_irq (
    .clk       (clk),
    .rstN      (rstN),
    .curBits   (dataBits),
    .prevBits  (prevBits),
    .dirBits   (dirBits),
    .senseBits (senseQ),
    .bothBits  (bothQ),
    .evtBits   (evtQ),
    .clrStb    (strobes.wrClear),
    .clrBits   (wrByte),
    .rawBits   (rawBits)
  );

  assign irqOut = |(rawBits & maskQ);

  always_comb begin
    case (strobes.rdSel)
      RD_DATA:   rd8 = dataBits & strobes.addrMask;
      RD_DIR:    rd8 = dirBits;
      RD_SENSE:  rd8 = senseQ;
      RD_BOTH:   rd8 = bothQ;
      RD_EVENT:  rd8 = evtQ;
      RD_MASK:   rd8 = maskQ;
      RD_RAW:    rd8 = rawBits;
      RD_MIS:    rd8 = rawBits & maskQ;
      RD_AFSEL:  rd8 = altFuncSel;
      RD_PAD:    rd8 = padQ[strobes.padIdx];
      RD_LOCK:   rd8 = {{(GPIO_PINS-1){1'b0}}, locked};
      RD_COMMIT: rd8 = commitMask;
      RD_ID:     rd8 = idByte(strobes.idIdx);
      default:   rd8 = '0;
    endcase
    busRdata = {{(BUS_DW-GPIO_PINS){1'b0}}, rd8};
  end

endmodule

// File: rtl/keyed_gpio.sv
module keyed_gpio
  import keyed_gpio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [BUS_AW-1:0]    busAddr,
  input  logic [BUS_DW-1:0]    busWdata,
  output logic [BUS_DW-1:0]    busRdata,
  input  logic [GPIO_PINS-1:0] pinIn,
  output logic [GPIO_PINS-1:0] pinOut,
  output logic [GPIO_PINS-1:0] altFuncSel,
  output logic                 irqOut
);

  gpioStrobes_t         strobes;
  logic                 locked;
  logic [GPIO_PINS-1:0] commitMask, dataBits, dirBits, rawBits;

  keyed_gpio_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .strobes    (strobes),
    .locked     (locked),
    .commitMask (commitMask)
  );

  keyed_gpio_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrByte     (busWdata[GPIO_PINS-1:0]),
    .pinIn      (pinIn),
    .locked     (locked),
    .commitMask (commitMask),
    .busRdata   (busRdata),
    .pinOut     (pinOut),
    .altFuncSel (altFuncSel),
    .dataBits   (dataBits),
    .dirBits    (dirBits),
    .rawBits    (rawBits),
    .irqOut     (irqOut)
  );

endmodule

// File: rtl/keyed_gpio_checker.sv
module keyed_gpio_checker
  import keyed_gpio_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWrite,
  input logic [BUS_AW-1:0]    busAddr,
  input logic [BUS_DW-1:0]    busWdata,
  input logic                 wrDataStb,
  input logic [GPIO_PINS-1:0] addrMaskQ,
  input logic                 locked,
  input logic [GPIO_PINS-1:0] commitMask,
  input logic [GPIO_PINS-1:0] altFuncSel,
  input logic [GPIO_PINS-1:0] dataBits,
  input logic [GPIO_PINS-1:0] dirBits,
  input logic [GPIO_PINS-1:0] pinOut,
  input logic [GPIO_PINS-1:0] rawBits
);

  // R3: output data bits move only under a data write whose mask covers them
  assert_data_guard_R3: assert property (@(posedge clk) disable iff (!rstN)
    (((dataBits ^ $past(dataBits)) & $past(dirBits) &
      ~($past(wrDataStb) ? $past(addrMaskQ) : '0)) == '0));

  // R5: pins configured as inputs never move
  assert_pin_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (((pinOut ^ $past(pinOut)) & ~$past(dirBits)) == '0));

  // R6: the key unlocks
  assert_key_unlocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFS_LOCK && busWdata == UNLOCK_KEY) |=> !locked);

  // R7: commit mask frozen while locked
  assert_commit_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFS_COMMIT && locked) |=> $stable(commitMask));

  // R7: uncommitted alternate-function bits never move
  assert_afsel_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    (((altFuncSel ^ $past(altFuncSel)) & ~$past(commitMask)) == '0));

  // R11: output pins never raise raw status
  assert_no_output_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((rawBits & ~$past(rawBits) & $past(dirBits)) == '0));

endmodule

bind keyed_gpio keyed_gpio_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busWrite   (busWrite),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .wrDataStb  (strobes.wrData),
  .addrMaskQ  (strobes.addrMask),
  .locked     (locked),
  .commitMask (commitMask),
  .altFuncSel (altFuncSel),
  .dataBits   (dataBits),
  .dirBits    (dirBits),
  .pinOut     (pinOut),
  .rawBits    (rawBits)
);

// File: tb/test_keyed_gpio.sv
`timescale 1ns/1ps
module test_keyed_gpio;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel, busWrite;
  logic [11:0] busAddr;
  logic [31:0] busWdata, busRdata;
  logic [7:0]  pinIn, pinOut, altFuncSel;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyed_gpio i_keyed_gpio (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .altFuncSel(altFuncSel), .irqOut(irqOut)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 v = busRdata;
    busSel = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRd(a, v);
    check(req, $sformatf("read %h", a), v, exp);
  endtask

  task automatic t_reset;
    rdCheck("R1", 12'h520, 32'h1);
    rdCheck("R1", 12'h524, 32'hFF);
    rdCheck("R1", 12'h400, 32'h0);
    rdCheck("R1", 12'h420, 32'h0);
    rdCheck("R1", 12'h410, 32'h0);
    rdCheck("R1", 12'h3FC, 32'h0);
    check("R1", "pinOut", pinOut, 8'h00);
    check("R1", "altFuncSel", altFuncSel, 8'h00);
    check("R1", "irqOut", irqOut, 1'b0);
  endtask

  task automatic t_ident;
    logic [7:0] expId [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00,
                               8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 12; i++)
      rdCheck("R9", 12'hFD0 + 12'(4 * i), {24'h0, expId[i]});
  endtask

  task automatic t_dataWrite;
    busWr(12'h400, 32'h0F);                 // low nibble outputs
    busWr(12'h3FC, 32'hFF);
    rdCheck("R3", 12'h3FC, 32'h0F);
    check("R5", "pinOut after full write", pinOut, 8'h0F);
    busWr(12'h014, 32'h00);                 // mask 0x05 clears bits 0,2
    rdCheck("R2", 12'h030, 32'h08);         // mask 0x0C
    check("R5", "pinOut after masked write", pinOut, 8'h0A);
    busWr(12'h3C0, 32'hFF);                 // mask covers inputs only
    rdCheck("R3", 12'h3FC, 32'h0A);
    rdCheck("R2", 12'h000, 32'h00);
  endtask

  task automatic t_inputs;
    pinIn = 8'hA5;
    @(negedge clk);
    rdCheck("R4", 12'h3FC, 32'hAA);
    check("R5", "pinOut ignores inputs", pinOut, 8'h0A);
    pinIn = 8'h5A;
    @(negedge clk);
    rdCheck("R4", 12'h3FC, 32'h5A);
  endtask

  task automatic t_regs;
    for (int k = 0; k < 8; k++)
      busWr(12'h500 + 12'(4 * k), 32'(8'h11 * k + 3));
    for (int k = 0; k < 8; k++)
      rdCheck("R8", 12'h500 + 12'(4 * k), 32'(8'(8'h11 * k + 3)));
    busWr(12'h404, 32'h3C); rdCheck("R8", 12'h404, 32'h3C);
    busWr(12'h408, 32'hC3); rdCheck("R8", 12'h408, 32'hC3);
    busWr(12'h40C, 32'h5A); rdCheck("R8", 12'h40C, 32'h5A);
    busWr(12'h410, 32'hA5); rdCheck("R8", 12'h410, 32'hA5);
    rdCheck("R8", 12'h400, 32'h0F);
    busWr(12'h404, 32'h0); busWr(12'h408, 32'h0);
    busWr(12'h40C, 32'h0); busWr(12'h410, 32'h0);
  endtask

  task automatic t_unmapped;
    busWr(12'h600, 32'hFF);
    busWr(12'h528, 32'hFF);
    busWr(12'h501, 32'hFF);                 // misaligned pad access
    rdCheck("R10", 12'h600, 32'h0);
    rdCheck("R10", 12'h528, 32'h0);
    rdCheck("R10", 12'h41C, 32'h0);
    rdCheck("R10", 12'h502, 32'h0);
    rdCheck("R10", 12'h500, 32'h03);
    rdCheck("R10", 12'h400, 32'h0F);
  endtask

  task automatic t_lock;
    busWr(12'h524, 32'h0F);
    rdCheck("R7", 12'h524, 32'hFF);
    busWr(12'h420, 32'hFF);
    rdCheck("R7", 12'h420, 32'hFF);
    busWr(12'h520, 32'h0ACCE551);
    rdCheck("R6", 12'h520, 32'h0);
    busWr(12'h524, 32'h0F);
    rdCheck("R7", 12'h524, 32'h0F);
    busWr(12'h420, 32'h00);
    rdCheck("R7", 12'h420, 32'hF0);
    check("R7", "altFuncSel port", altFuncSel, 8'hF0);
    busWr(12'h520, 32'h0ACCE550);
    rdCheck("R6", 12'h520, 32'h1);
    busWr(12'h524, 32'h00);
    rdCheck("R7", 12'h524, 32'h0F);
  endtask

  task automatic t_edge;
    pinIn = 8'h00;
    busWr(12'h400, 32'h00);                 // all inputs
    repeat (3) @(negedge clk);
    busWr(12'h408, 32'h02);                 // bit1 any edge
    busWr(12'h40C, 32'h01);                 // bit0 rising, others falling
    busWr(12'h410, 32'hFF);
    busWr(12'h41C, 32'hFF);
    rdCheck("R13", 12'h414, 32'h00);
    check("R14", "irqOut idle", irqOut, 1'b0);
    pinIn = 8'h07;
    @(negedge clk);
    rdCheck("R11", 12'h414, 32'h03);
    check("R14", "irqOut raised", irqOut, 1'b1);
    pinIn = 8'h00;
    @(negedge clk);
    rdCheck("R11", 12'h414, 32'h07);
    busWr(12'h41C, 32'h05);
    rdCheck("R13", 12'h414, 32'h02);
    busWr(12'h410, 32'h01);
    rdCheck("R14", 12'h418, 32'h00);
    check("R14", "irqOut masked", irqOut, 1'b0);
    busWr(12'h410, 32'h02);
    rdCheck("R14", 12'h418, 32'h02);
    check("R14", "irqOut unmasked", irqOut, 1'b1);
  endtask

  task automatic t_level;
    busWr(12'h408, 32'h00);
    busWr(12'h40C, 32'h10);
    busWr(12'h404, 32'h10);                 // bit4 level, high active
    busWr(12'h410, 32'h10);
    busWr(12'h41C, 32'hFF);
    rdCheck("R12", 12'h414, 32'h00);
    pinIn = 8'h10;
    @(negedge clk);
    rdCheck("R12", 12'h414, 32'h10);
    check("R14", "irqOut level", irqOut, 1'b1);
    busWr(12'h41C, 32'h10);
    rdCheck("R13", 12'h414, 32'h10);
    pinIn = 8'h00;
    @(negedge clk);
    rdCheck("R12", 12'h414, 32'h00);
    check("R14", "irqOut level low", irqOut, 1'b0);
  endtask

  initial begin
    rstN = 1'b0; busSel = 1'b0; busWrite = 1'b0;
    busAddr = '0; busWdata = '0; pinIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ident();
    t_dataWrite();
    t_inputs();
    t_regs();
    t_unmapped();
    t_lock();
    t_edge();
    t_level();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog (R1..R14 flow): actual=timeout expected=completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule